// File: doc/BRIEF.md
# Bit-Serial Signed Inner-Product Unit

This unit forms the inner product of sixteen unsigned activations and sixteen two's-complement weights. Both operands arrive one bit-plane at a time, least significant plane first. On every active step the unit ANDs sixteen activation bits with sixteen weight bits, counts the ones, and folds that count into a running sum. The count is scaled by the activation bit index. After one full pass over the activation planes, that inner sum is scaled by the weight bit index and merged into a 32-bit signed result. The merge is a subtraction when the weight plane is the sign plane. Precisions for both operands are chosen per job, from 1 to 16 bits, so execution time is the product of the two precisions.

The same result register has two further uses. It can add a value arriving from a neighbouring unit, so that partial sums split across a row of units can be reduced. It can also keep the running signed maximum of a stream of values, which supports max pooling.

Top module: `serial_dot_unit`

## Requirements
- R1: A `start` pulse clears `acc` to 0 and holds `done` low in the next cycle. It also latches `act_prec` and `wgt_prec`; each field holds the precision minus one, so 0 means 1 bit and 15 means 16 bits.
- R2: Each accepted step adds the count of lanes where both bits are 1, scaled by 2^(i+j). Here i is the activation bit index and j is the weight bit index, and both indices start at 0 after `start`. i advances on every step, and j advances and i returns to 0 after Pa steps.
- R3: Weight bits are captured from `wbits` only on a step with i = 0 and are reused for the other Pa-1 steps. The value on `wbits` during those other steps has no effect.
- R4: Contributions from the highest weight plane (j = Pw-1) are subtracted, so that weights are Pw-bit two's complement. With Pw = 1 a set weight bit means -1.
- R5: The inner sum for weight plane j is merged into `acc` on the step with i = Pa-1. After the Pa×Pw-th step, `acc` equals the signed inner product modulo 2^32, and `done` is high for exactly that one cycle.
- R6: `step` pulses arriving after a job has completed and before the next `start` leave `acc` unchanged and do not raise `done`.
- R7: A cycle with none of `start`, `step`, `casc_add` or `pool_en` high leaves `acc` unchanged.
- R8: `casc_add` adds the signed value on `side_in` to `acc`.
- R9: The first `pool_en` after `start` loads `side_in` into `acc`. Each later `pool_en` keeps the signed maximum of `acc` and `side_in`.
- R10: When several controls are high in the same cycle, `start` wins over `step`, `step` wins over `casc_add`, and `casc_add` wins over `pool_en`. A `step` issued while idle still blocks the lower-priority controls in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new job; clears result and latches precisions |
| act_prec | input | 4 | Activation precision minus one |
| wgt_prec | input | 4 | Weight precision minus one |
| step | input | 1 | Consume one activation bit-plane |
| abits | input | 16 | Activation bits, one per lane |
| wbits | input | 16 | Weight bits, one per lane, captured when i = 0 |
| casc_add | input | 1 | Add `side_in` into the result |
| pool_en | input | 1 | Max-pool `side_in` into the result |
| side_in | input | 32 | Signed cascade or pooling operand |
| acc | output | 32 | Signed result register |
| done | output | 1 | One-cycle pulse on the final merge |

## Verification
The hardest condition to reach is a weight register that holds a stale value while `wbits` carries something else. A bug that reads `wbits` on every step would otherwise go unseen. The stimulus therefore drives the inverse of the true weight plane on every step with i > 0, and compares the final result against an integer dot product. The sign-plane subtraction is reached with weight precisions of 1, 4 and 16 bits, using vectors that contain negative weights. These are combined with stretches where `step` is low and with steps issued after the job has completed.

// File: rtl/serial_dot_unit.sv
module serial_dot_unit #(
  parameter int LANES = 16,
  parameter int ACC_W = 32,
  parameter int PF_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PF_W-1:0]         act_prec,
  input  logic [PF_W-1:0]         wgt_prec,
  input  logic                    step,
  input  logic [LANES-1:0]        abits,
  input  logic [LANES-1:0]        wbits,
  input  logic                    casc_add,
  input  logic                    pool_en,
  input  logic signed [ACC_W-1:0] side_in,
  output logic signed [ACC_W-1:0] acc,
  output logic                    done
);
  localparam int MAXB  = 1 << PF_W;
  localparam int SUM_W = $clog2(LANES + 1);
  localparam int IN_W  = SUM_W + MAXB;

  logic [LANES-1:0] wr;
  logic [PF_W-1:0]  a_idx, w_idx, pa_m1, pw_m1;
  logic             busy, pooled;
  logic [IN_W-1:0]  inner;

  logic [LANES-1:0] w_eff;
  logic [SUM_W-1:0] pc;
  logic [IN_W-1:0]  inner_sum;
  logic [ACC_W-1:0] contrib;
  logic             last_a, last_w;

  assign w_eff = (a_idx == '0) ? wbits : wr;

  always_comb begin
    pc = '0;
    for (int k = 0; k < LANES; k++)
      pc = pc + SUM_W'(abits[k] & w_eff[k]);
  end

  assign inner_sum = inner + (IN_W'(pc) << a_idx);
  assign contrib   = ACC_W'(inner_sum) << w_idx;
  assign last_a    = (a_idx == pa_m1);
  assign last_w    = (w_idx == pw_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr <= '0; a_idx <= '0; w_idx <= '0; pa_m1 <= '0; pw_m1 <= '0;
      busy <= 1'b0; pooled <= 1'b0; inner <= '0; acc <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc <= '0; inner <= '0; a_idx <= '0; w_idx <= '0;
        pa_m1 <= act_prec; pw_m1 <= wgt_prec;
        busy <= 1'b1; pooled <= 1'b0;
      end else if (step) begin
        if (busy) begin
          if (a_idx == '0) wr <= wbits;
          if (last_a) begin
            inner <= '0;
            a_idx <= '0;
            acc   <= last_w ? acc - $signed(contrib) : acc + $signed(contrib);
            if (last_w) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              w_idx <= w_idx + 1'b1;
            end
          end else begin
            inner <= inner_sum;
            a_idx <= a_idx + 1'b1;
          end
        end
      end else if (casc_add) begin
        acc <= acc + side_in;
      end else if (pool_en) begin
        if (!pooled || side_in > acc) acc <= side_in;
        pooled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_dot_unit_chk.sv
module serial_dot_unit_chk #(
  parameter int ACC_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    step,
  input logic                    casc_add,
  input logic                    pool_en,
  input logic signed [ACC_W-1:0] side_in,
  input logic signed [ACC_W-1:0] acc,
  input logic                    done,
  input logic                    busy,
  input logic                    pooled
);
  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc == '0) && !done);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !busy) |=> $stable(acc) && !done);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step && !casc_add && !pool_en) |=> $stable(acc));
  // R9
  pool_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_en && !start && !step && !casc_add) |=> (acc >= $past(side_in)));
  // R9
  pool_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_en && pooled && !start && !step && !casc_add) |=> (acc >= $past(acc)));
endmodule

bind serial_dot_unit serial_dot_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step), .casc_add(casc_add),
  .pool_en(pool_en), .side_in(side_in), .acc(acc), .done(done),
  .busy(busy), .pooled(pooled)
);

// File: tb/serial_dot_unit_bench.sv
module serial_dot_unit_bench;
  logic clk = 0, rst_n = 0;
  logic start = 0, step = 0, casc_add = 0, pool_en = 0;
  logic [3:0] act_prec = 0, wgt_prec = 0;
  logic [15:0] abits = 0, wbits = 0;
  logic signed [31:0] side_in = 0;
  logic signed [31:0] acc;
  logic done;

  int n_checks = 0, n_fail = 0, cyc = 0;

  // behavioural model state
  logic signed [31:0] m_acc = 0;
  longint m_part = 0;
  bit m_busy = 0, m_done = 0, m_pooled = 0;
  int m_ai = 0, m_wi = 0, m_pa = 1, m_pw = 1;
  logic [15:0] m_wreg = 0;

  serial_dot_unit u_serial_dot_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .act_prec(act_prec), .wgt_prec(wgt_prec),
    .step(step), .abits(abits), .wbits(wbits), .casc_add(casc_add), .pool_en(pool_en),
    .side_in(side_in), .acc(acc), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
    summary();
  end

  task automatic check(string req, logic signed [31:0] act, logic signed [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_edge(bit s, bit st, logic [15:0] ab, logic [15:0] wb,
                                     bit ca, bit pe, logic signed [31:0] si,
                                     logic [3:0] ap, logic [3:0] wp);
    logic [15:0] we;
    m_done = 0;
    if (s) begin
      m_acc = 0; m_part = 0; m_busy = 1; m_ai = 0; m_wi = 0;
      m_pa = ap + 1; m_pw = wp + 1; m_pooled = 0;
    end else if (st) begin
      if (m_busy) begin
        we = (m_ai == 0) ? wb : m_wreg;
        if (m_ai == 0) m_wreg = wb;
        for (int k = 0; k < 16; k++)
          if (ab[k] && we[k]) begin
            if (m_wi == m_pw - 1) m_part -= (64'sd1 << (m_ai + m_wi));
            else m_part += (64'sd1 << (m_ai + m_wi));
          end
        if (m_ai == m_pa - 1) begin
          m_acc = m_acc + m_part[31:0];
          m_part = 0; m_ai = 0;
          if (m_wi == m_pw - 1) begin m_busy = 0; m_done = 1; end
          else m_wi++;
        end else m_ai++;
      end
    end else if (ca) m_acc = m_acc + si;
    else if (pe) begin
      if (!m_pooled || si > m_acc) m_acc = si;
      m_pooled = 1;
    end
  endfunction

  // one clock: drive on negedge, model, compare after the edge
  task automatic cyc1(string req, bit s, bit st, logic [15:0] ab, logic [15:0] wb,
                      bit ca, bit pe, logic signed [31:0] si);
    @(negedge clk);
    start = s; step = st; abits = ab; wbits = wb; casc_add = ca; pool_en = pe; side_in = si;
    model_edge(s, st, ab, wb, ca, pe, si, act_prec, wgt_prec);
    @(posedge clk); #1;
    check({req, " acc"}, acc, m_acc);
    check({req, " done"}, {31'd0, done}, {31'd0, m_done});
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cyc1(req, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // full job; corrupt=1 drives inverted weight bits on i>0 steps (R3)
  task automatic run_dot(int pa, int pw, int a[16], int w[16], bit corrupt, bit gaps, string req);
    longint gold = 0;
    logic signed [31:0] g32;
    logic [15:0] ab, wb;
    act_prec = 4'(pa - 1); wgt_prec = 4'(pw - 1);
    cyc1("R1", 1, 0, 0, 0, 0, 0, 0);
    check("R1 clear", acc, 0);
    for (int k = 0; k < 16; k++) begin
      longint ws = w[k] & ((1 << pw) - 1);
      if (ws >= (64'sd1 << (pw - 1))) ws -= (64'sd1 << pw);
      gold += longint'(a[k] & ((1 << pa) - 1)) * ws;
    end
    for (int j = 0; j < pw; j++)
      for (int i = 0; i < pa; i++) begin
        for (int k = 0; k < 16; k++) begin ab[k] = a[k][i]; wb[k] = w[k][j]; end
        if (corrupt && i != 0) wb = ~wb;
        cyc1(req, 0, 1, ab, wb, 0, 0, 0);
        if (gaps && i == 0) idle(2, "R7");
      end
    g32 = gold[31:0];
    check({req, " R5 final product"}, acc, g32);
    check("R5 done pulse", {31'd0, done}, 32'd1);
    idle(1, "R5");
    check("R5 done single", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int a[16], w[16];
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset acc", acc, 0);
    check("R1 reset done", {31'd0, done}, 32'd0);
    rst_n = 1;
    idle(2, "R7");

    // R2 simple: all activations 3, weights 1, 2-bit each => 16*3*1 = 48
    for (int k = 0; k < 16; k++) begin a[k] = 3; w[k] = 1; end
    run_dot(2, 2, a, w, 0, 0, "R2");
    // R4 single-bit weights (set bit = -1)
    for (int k = 0; k < 16; k++) begin a[k] = k; w[k] = k & 1; end
    run_dot(4, 1, a, w, 0, 0, "R4");
    // mixed signed with corrupted hold-phase weights (R3) and gaps (R7)
    for (int k = 0; k < 16; k++) begin a[k] = $urandom & 15; w[k] = $urandom & 15; end
    run_dot(4, 4, a, w, 1, 1, "R3");
    // full 16-bit weights, negatives
    for (int k = 0; k < 16; k++) begin a[k] = $urandom & 7; w[k] = (k < 8) ? -(k * 1000 + 7) : k * 999; end
    run_dot(3, 16, a, w, 1, 0, "R4");
    // 16-bit activations, 8-bit weights
    for (int k = 0; k < 16; k++) begin a[k] = $urandom & 16'hffff; w[k] = $urandom & 8'hff; end
    run_dot(16, 8, a, w, 1, 0, "R2");
    // 1x1
    for (int k = 0; k < 16; k++) begin a[k] = 1; w[k] = (k < 5); end
    run_dot(1, 1, a, w, 0, 0, "R4");
    check("R4 1x1 value", acc, -5);

    // R6 idle steps after completion
    for (int i = 0; i < 4; i++) cyc1("R6", 0, 1, 16'hffff, 16'hffff, 0, 0, 0);
    check("R6 unchanged", acc, -5);

    // R8 cascade adds
    cyc1("R8", 0, 0, 0, 0, 1, 0, 32'sd1000);
    check("R8 add", acc, 995);
    cyc1("R8", 0, 0, 0, 0, 1, 0, -32'sd2000);
    check("R8 add neg", acc, -1005);

    // R10 idle step still blocks cascade and pool
    cyc1("R10", 0, 1, 16'hffff, 16'hffff, 1, 1, 32'sd77);
    check("R10 step blocks", acc, -1005);
    // R10 casc beats pool
    cyc1("R10", 0, 0, 0, 0, 1, 1, 32'sd5);
    check("R10 casc over pool", acc, -1000);

    // R9 pooling after start: first load, then max
    act_prec = 0; wgt_prec = 0;
    cyc1("R1", 1, 0, 0, 0, 0, 0, 0);
    cyc1("R9", 0, 0, 0, 0, 0, 1, -32'sd50);
    check("R9 first load", acc, -50);
    cyc1("R9", 0, 0, 0, 0, 0, 1, -32'sd80);
    check("R9 keep max", acc, -50);
    cyc1("R9", 0, 0, 0, 0, 0, 1, 32'sd12);
    check("R9 new max", acc, 12);
    idle(2, "R7");

    // R10 start beats step in same cycle
    act_prec = 1; wgt_prec = 1;
    cyc1("R10", 1, 1, 16'hffff, 16'hffff, 0, 0, 0);
    check("R10 start wins", acc, 0);
    for (int i = 0; i < 4; i++) cyc1("R2", 0, 1, 16'h0001, 16'h0001, 0, 0, 0);
    // lane0 a=3, w=3 (2-bit signed -1) => -3
    check("R4 2x2 value", acc, -3);
    idle(3, "R7");
    summary();
  end
endmodule